// File: doc/BRIEF.md
# ADC Busy-Indicator Read Controller

This host-side controller runs one 18-bit successive-approximation converter whose serial output doubles as an end-of-conversion flag. The converter's data-in pin is strapped high and its turbo control is held low. When `start_i` is seen, the controller pulses the convert pin high for a short, fixed time. It then drops the pin and keeps it low for the rest of the transaction. The converter's serial output floats during conversion and a pull-up holds it at 1. The controller watches that line through a two-flop synchronizer. The first low level it sees marks the end of conversion.

Once the low level is seen, the controller makes serial clock pulses with parameterised high and low times. Falling edge k (k = 1 to 18) makes the converter present result bit 18-k, so the word arrives MSB first. The controller samples each bit in the last system-clock cycle of the low phase that follows its edge. It then gives a 19th falling edge, which returns the converter output to high impedance. The assembled word appears on `data_o` with a one-cycle `valid_o` strobe. A quiet interval follows before another start is accepted. If the end-of-conversion low never comes, a timeout ends the transaction with a one-cycle `timeout_o` pulse.

`SCK_LO_CYC` must cover the synchronizer latency plus the converter's output delay in system-clock cycles. The default of 4 allows for two sync stages plus one cycle of board and output delay.

Top module: `adc_busy_reader`

## Requirements
- R1: When `start_i` is high and `busy_o` is low at a rising clock edge, `cnv_o` is high from the next cycle for exactly `CNV_HIGH_CYC` cycles and then goes low.
- R2: After it falls, `cnv_o` stays low until `busy_o` has returned low. `sck_o` is never high while `cnv_o` is high.
- R3: No serial clock pulse is issued until the synchronized data line has been seen low after the convert pulse.
- R4: A successful read gives exactly 19 falling edges on `sck_o`. Each high phase lasts `SCK_HI_CYC` cycles and each low phase between two pulses lasts `SCK_LO_CYC` cycles.
- R5: The bit present after falling edge k (k = 1 to 18) goes into result bit 18-k. `data_o` equals the 18-bit word the converter sent, MSB first.
- R6: `valid_o` is a single-cycle pulse issued once per successful read, in the same cycle as the new `data_o`. `data_o` does not change in any other cycle.
- R7: If the data line is not seen low within `TIMEOUT_CYC` cycles after `cnv_o` falls, `timeout_o` pulses for one cycle. No serial clock and no `valid_o` follow, and a late low on the line has no effect.
- R8: `busy_o` stays high for exactly `QUIET_CYC` cycles counted from the cycle that shows `valid_o` or `timeout_o`, then goes low.
- R9: `start_i` is ignored while `busy_o` is high: exactly one convert pulse occurs per transaction.
- R10: During reset, `cnv_o`, `sck_o`, `valid_o`, `timeout_o` and `busy_o` are 0 and `data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion and read |
| busy_o | output | 1 | Transaction in progress, including the quiet interval |
| cnv_o | output | 1 | Convert pin to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Pulled-up serial data and end-of-conversion line |
| data_o | output | DATA_W | Last assembled result |
| valid_o | output | 1 | One-cycle strobe for a new result |
| timeout_o | output | 1 | One-cycle strobe when the end-of-conversion low does not arrive |

## Verification
The hardest case to reach is the timeout path followed by a late end-of-conversion low. The converter model is set to drop its line only after the controller has given up, and the bench then lets several dozen idle cycles pass. It counts clock edges and strobes in that window, so any reaction to the stale low shows up. Random words and conversion delays are mixed with extra start pulses fired mid-transaction. Each convert pulse must stay single and each read must keep its exact 19-edge shape.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CNV   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SCKH  = 3'd3,
        ST_SCKL  = 3'd4,
        ST_QUIET = 3'd5
    } rd_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (en_i) word_d = {word_q[W-2:0], bit_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/adc_busy_reader.sv
module adc_busy_reader
    import adc_rd_pkg::*;
#(
    parameter int DATA_W       = 18,
    parameter int CNV_HIGH_CYC = 3,
    parameter int SCK_HI_CYC   = 2,
    parameter int SCK_LO_CYC   = 4,
    parameter int QUIET_CYC    = 5,
    parameter int TIMEOUT_CYC  = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              cnv_o,
    output logic              sck_o,
    input  logic              sdo_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              timeout_o
);
    localparam int EDGES   = DATA_W + 1;
    localparam int EDGE_W  = $clog2(EDGES + 1);
    localparam int MAX_CYC = max2(max2(CNV_HIGH_CYC, TIMEOUT_CYC),
                                  max2(max2(SCK_HI_CYC, SCK_LO_CYC), QUIET_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        rd_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [EDGE_W-1:0]  edges;
        logic               cnv;
        logic               sck;
        logic               valid;
        logic               tmo;
        logic [DATA_W-1:0]  data;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              sdo_s;
    logic              shift_en;
    logic [DATA_W-1:0] shift_word;

    adc_rd_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sdo_i),
        .sync_o  (sdo_s)
    );

    adc_rd_shift #(.W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (shift_en),
        .bit_i  (sdo_s),
        .word_o (shift_word)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        ctl_d.tmo   = 1'b0;
        shift_en    = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st  = ST_CNV;
                    ctl_d.cnv = 1'b1;
                    ctl_d.cnt = CNT_W'(CNV_HIGH_CYC - 1);
                end
            end
            ST_CNV: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st    = ST_WAIT;
                    ctl_d.cnv   = 1'b0;
                    ctl_d.cnt   = CNT_W'(TIMEOUT_CYC - 1);
                    ctl_d.edges = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_WAIT: begin
                if (!sdo_s) begin
                    ctl_d.st  = ST_SCKH;
                    ctl_d.sck = 1'b1;
                    ctl_d.cnt = CNT_W'(SCK_HI_CYC - 1);
                end else if (ctl_q.cnt == '0) begin
                    ctl_d.st  = ST_QUIET;
                    ctl_d.tmo = 1'b1;
                    ctl_d.cnt = CNT_W'(QUIET_CYC - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_SCKH: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st    = ST_SCKL;
                    ctl_d.sck   = 1'b0;
                    ctl_d.cnt   = CNT_W'(SCK_LO_CYC - 1);
                    ctl_d.edges = ctl_q.edges + 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_SCKL: begin
                if (ctl_q.cnt == '0) begin
                    if (ctl_q.edges == EDGE_W'(EDGES)) begin
                        ctl_d.st    = ST_QUIET;
                        ctl_d.valid = 1'b1;
                        ctl_d.data  = shift_word;
                        ctl_d.cnt   = CNT_W'(QUIET_CYC - 1);
                    end else begin
                        shift_en  = 1'b1;
                        ctl_d.st  = ST_SCKH;
                        ctl_d.sck = 1'b1;
                        ctl_d.cnt = CNT_W'(SCK_HI_CYC - 1);
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_QUIET: begin
                if (ctl_q.cnt == '0) ctl_d.st = ST_IDLE;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = (ctl_q.st != ST_IDLE);
    assign cnv_o     = ctl_q.cnv;
    assign sck_o     = ctl_q.sck;
    assign data_o    = ctl_q.data;
    assign valid_o   = ctl_q.valid;
    assign timeout_o = ctl_q.tmo;

    // R2: serial clock and convert pulse never overlap
    a_r2_no_clock_during_convert: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cnv_o);

    // R1: a convert pulse starts only from an accepted request
    a_r1_convert_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> ($past(start_i) && !$past(busy_o)));

    // R9: a request while busy does not start another convert pulse
    a_r9_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !$rose(cnv_o));

    // R6: strobe lasts one cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: result only moves with the strobe
    a_r6_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    // R7: timeout excludes a result and a clock pulse
    a_r7_timeout_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && !sck_o));

    // R3: the first clock pulse follows a seen-low data line
    a_r3_clock_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sck_o) && $past(ctl_q.st == ST_WAIT)) |-> !$past(sdo_s));
endmodule

// File: tb/tb_adc_busy_reader.sv
module tb_adc_busy_reader;
    localparam int DW    = 18;
    localparam int CNVH  = 3;
    localparam int SHI   = 2;
    localparam int SLO   = 4;
    localparam int QUIET = 5;
    localparam int TMO   = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_o, cnv_o, sck_o, valid_o, timeout_o;
    logic sdo_m;
    logic [DW-1:0] data_o;

    always #4 clk = ~clk;

    adc_busy_reader #(
        .DATA_W(DW), .CNV_HIGH_CYC(CNVH), .SCK_HI_CYC(SHI),
        .SCK_LO_CYC(SLO), .QUIET_CYC(QUIET), .TIMEOUT_CYC(TMO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
        .cnv_o(cnv_o), .sck_o(sck_o), .sdo_i(sdo_m), .data_o(data_o),
        .valid_o(valid_o), .timeout_o(timeout_o)
    );

    // converter model
    logic [DW-1:0] m_word = '0;
    int            m_delay = 20;
    int            conv_left;
    int            idx;
    logic          cnv_prev, sck_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            sdo_m <= 1'b1; conv_left <= 0; idx <= 0;
            cnv_prev <= 1'b0; sck_prev <= 1'b0;
        end else begin
            cnv_prev <= cnv_o;
            sck_prev <= sck_o;
            if (cnv_o && !cnv_prev) begin
                conv_left <= m_delay; sdo_m <= 1'b1; idx <= 0;
            end else if (conv_left > 0) begin
                if (conv_left == 1) sdo_m <= 1'b0;
                conv_left <= conv_left - 1;
            end else if (!sck_o && sck_prev) begin
                if (idx < DW) sdo_m <= m_word[DW-1-idx];
                else          sdo_m <= 1'b1;
                idx <= idx + 1;
            end
        end
    end

    // monitor, sampled on the falling clock edge
    int n_cnv_rise = 0, cnv_run = 0, cnv_bad = 0;
    int hi_run = 0, lo_run = 0, hi_bad = 0, lo_bad = 0, n_fall = 0;
    int n_valid = 0, n_tmo = 0, quiet_cnt = 0, early_sck = 0, overlap = 0;
    int cycles = 0;
    logic end_seen = 1'b0, seen_fall = 1'b0, c_prev = 1'b0, s_prev = 1'b0;
    logic [DW-1:0] cap = '0;
    int checks = 0, fails = 0;

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (cnv_o && !c_prev) begin
                n_cnv_rise++; end_seen = 1'b0; quiet_cnt = 0; seen_fall = 1'b0;
            end
            if (cnv_o) cnv_run++;
            else if (cnv_run != 0) begin
                if (cnv_run != CNVH) cnv_bad++;
                cnv_run = 0;
            end
            if (sck_o) begin
                if (!s_prev && seen_fall && lo_run != SLO) lo_bad++;
                if (conv_left > 0) early_sck++;
                if (cnv_o) overlap++;
                hi_run++;
            end else if (s_prev) begin
                n_fall++;
                if (hi_run != SHI) hi_bad++;
                hi_run = 0; seen_fall = 1'b1; lo_run = 1;
            end else begin
                lo_run++;
            end
            if (busy_o && !cnv_o && c_prev === 1'b0 && $past(cnv_o)) overlap += 0;
            if (valid_o) begin n_valid++; cap = data_o; end_seen = 1'b1; end
            if (timeout_o) begin n_tmo++; end_seen = 1'b1; end
            if (end_seen && busy_o) quiet_cnt++;
            c_prev = cnv_o;
            s_prev = sck_o;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_conv(input logic [DW-1:0] word, input int delay,
                            input bit exp_tmo, input int extra_at);
        int b_rise, b_cnvbad, b_hi, b_lo, b_fall, b_val, b_tmo, b_early, b_ovl;
        int lowcnv_bad;
        m_word  = word;
        m_delay = delay;
        b_rise = n_cnv_rise; b_cnvbad = cnv_bad; b_hi = hi_bad; b_lo = lo_bad;
        b_fall = n_fall; b_val = n_valid; b_tmo = n_tmo; b_early = early_sck;
        b_ovl = overlap; lowcnv_bad = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int i = 0; i < 4000 && busy_o; i++) begin
            if (i == extra_at) start_i = 1'b1;
            else               start_i = 1'b0;
            if (i > CNVH + 1 && cnv_o) lowcnv_bad++;
            @(negedge clk);
        end
        start_i = 1'b0;
        if (exp_tmo) repeat (80) @(negedge clk);
        chk(n_cnv_rise - b_rise == 1, "R9", n_cnv_rise - b_rise, 1);
        chk(cnv_bad == b_cnvbad, "R1", cnv_bad - b_cnvbad, 0);
        chk(lowcnv_bad == 0 && overlap == b_ovl, "R2", lowcnv_bad, 0);
        chk(early_sck == b_early, "R3", early_sck - b_early, 0);
        chk(hi_bad == b_hi && lo_bad == b_lo, "R4", hi_bad - b_hi + lo_bad - b_lo, 0);
        chk(n_fall - b_fall == (exp_tmo ? 0 : DW + 1), "R4", n_fall - b_fall, exp_tmo ? 0 : DW + 1);
        chk(n_valid - b_val == (exp_tmo ? 0 : 1), "R6", n_valid - b_val, exp_tmo ? 0 : 1);
        chk(n_tmo - b_tmo == (exp_tmo ? 1 : 0), "R7", n_tmo - b_tmo, exp_tmo ? 1 : 0);
        if (!exp_tmo) chk(cap == word, "R5", cap, word);
        chk(quiet_cnt == QUIET, "R8", quiet_cnt, QUIET);
    endtask

    initial begin
        int unsigned seed = 32'h00c0ffee;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        chk(!cnv_o && !sck_o && !valid_o && !timeout_o && !busy_o && data_o == '0,
            "R10", {cnv_o, sck_o, valid_o, timeout_o, busy_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !cnv_o, "R10", busy_o, 0);

        run_conv(18'h3FFFF, 12, 1'b0, -1);
        run_conv(18'h00000, 40, 1'b0, -1);
        run_conv(18'h20000, 9, 1'b0, 1);
        run_conv(18'h00001, 100, 1'b0, 20);
        run_conv(18'h2AAAA, 60, 1'b0, -1);
        run_conv(18'h15555, TMO + 60, 1'b1, 5);
        run_conv(18'h1C3A5, 25, 1'b0, -1);
        for (int t = 0; t < 40; t++) begin
            logic [DW-1:0] w;
            int dly, ex;
            w   = DW'($urandom());
            dly = 8 + int'($urandom_range(0, 150));
            ex  = (($urandom() & 1) != 0) ? int'($urandom_range(0, 60)) : -1;
            run_conv(w, dly, 1'b0, ex);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule